// File: doc/BRIEF.md
# DMA Stream Priority Arbiter

This block chooses which of several DMA streams may use a shared transfer engine next. Each stream is configured through a single write port. The configuration gives the stream an enable, the number of the peripheral request line it listens to, a two-bit priority, an item count, a circular-mode bit and a software-trigger bit for memory-to-memory work. The enabled stream that is requesting and has the highest priority wins. When two or more requesting streams share that priority, the one with the lowest index wins.

A grant stays in place until the engine reports that the single transfer (beat) has finished. The engine reports this with a one-cycle done strobe, which also carries three error bits. The arbiter holds no grant in the cycle after a beat and decides again in the cycle after that. Each stream keeps a count of the items it still has to move. It raises sticky event flags for half transfer, transfer complete and three error kinds. Software clears these flags with a write-one-to-clear port. Each stream also drives one interrupt line, which is the OR of its five flags.

Top module: `dma_stream_arb`

## Requirements
- R1: After reset, grant_valid is 0, every stream is inactive, every event flag is 0 and every irq bit is 0.
- R2: A stream requests only when it is active and the request line whose index equals its programmed channel number is 1. Lines that other streams select have no effect on it, and a stream that is not active never receives a grant.
- R3: Among the requesting streams, the one with the largest priority code wins: 3 is very high, 2 high, 1 medium and 0 low.
- R4: Among requesting streams that share the largest priority code, the one with the lowest index wins.
- R5: A grant keeps the same stream until beat_done arrives. grant_valid is 0 in the cycle after a beat_done, and arbitration runs again on the cycle after that.
- R6: A configuration write loads the remaining count with cfg_count, which may be 1 to 65535. A write with enable set and a count of 0 leaves the stream inactive.
- R7: Flag bit 0 (half transfer) sets when an error-free beat leaves a remaining count equal to the programmed count shifted right by one.
- R8: Flag bit 1 (complete) sets when an error-free beat leaves a remaining count of 0. Without circular mode, the stream then becomes inactive.
- R9: In circular mode, a completed stream reloads its programmed count, stays active and keeps being granted.
- R10: beat_err bits 0, 1 and 2 set flag bits 2 (transfer error), 3 (FIFO error) and 4 (direct mode error) of the granted stream. Any error makes the stream inactive, and the beat does not count as an item.
- R11: Flags are sticky and are cleared only by a clear write, where a 1 in clr_mask clears the flag at the same bit position of the selected stream. Flags whose mask bit is 0 are not touched.
- R12: irq[s] is the OR of stream s's five flags.
- R13: A stream with the software-trigger bit set requests whenever it is active, without using any request line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SID_W | Stream being configured |
| cfg_en | input | 1 | Enable for the configured stream |
| cfg_chan | input | CH_W | Request line number the stream listens to |
| cfg_prio | input | 2 | Priority code (3 is highest) |
| cfg_count | input | CNT_W | Item count |
| cfg_circ | input | 1 | Circular mode |
| cfg_m2m | input | 1 | Software trigger (memory-to-memory) |
| clr_we | input | 1 | Flag clear strobe |
| clr_sel | input | SID_W | Stream whose flags are cleared |
| clr_mask | input | 5 | Write-one-to-clear mask |
| chan_req | input | N_CHAN | Peripheral request lines |
| beat_done | input | 1 | Engine finished the granted beat |
| beat_err | input | 3 | Error bits that come with beat_done |
| grant_valid | output | 1 | A stream holds the engine |
| grant_sel | output | SID_W | Index of the granted stream |
| stream_active | output | N_STREAMS | Stream enabled state |
| evt_flags | output | N_STREAMS*5 | Flags; stream s uses bits s*5 to s*5+4 |
| irq | output | N_STREAMS | Interrupt per stream |

## Verification
The bench uses the default build: eight streams, eight request lines and a 16-bit count. With this build, every priority code and every tie between neighbouring and distant indices can be reached from a table of request masks. The small counts used (1, 2 and 4) make the half-transfer point, the completion point, the circular reload and the single-item case where half and complete would coincide all reachable within a few beats. A stream listening to a line other than its own index shows that the channel mux uses the programmed channel number.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W  = 2;
  localparam int FLAG_W  = 5;
  localparam int ERR_W   = 3;
  localparam int FL_HALF = 0;
  localparam int FL_DONE = 1;
  localparam int FL_XERR = 2;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/dma_req_mux.sv
module dma_req_mux #(
  parameter int N_CHAN = 8,
  localparam int CH_W = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic [N_CHAN-1:0] chan_req,
  input  logic [CH_W-1:0]   chan,
  input  logic              active,
  input  logic              m2m,
  output logic              req
);
  logic line;

  always_comb begin
    line = 1'b0;
    for (int c = 0; c < N_CHAN; c++)
      if (chan == CH_W'(c)) line = chan_req[c];
  end

  // R2 / R13: a line request or the software trigger, and only while active
  assign req = active && (m2m || line);
endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick
  import dma_arb_pkg::*;
#(
  parameter int N_STREAMS = 8,
  localparam int SID_W = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1
) (
  input  logic [N_STREAMS-1:0]        req,
  input  logic [N_STREAMS*PRIO_W-1:0] prio_flat,
  output logic                        any,
  output logic [SID_W-1:0]            win
);
  prio_t best;

  // Scan downward with >=, so a lower index takes over on an equal code (R4)
  always_comb begin
    any  = 1'b0;
    win  = '0;
    best = '0;
    for (int i = N_STREAMS - 1; i >= 0; i--) begin
      if (req[i] && (!any || prio_flat[i*PRIO_W +: PRIO_W] >= best)) begin
        any  = 1'b1;
        best = prio_flat[i*PRIO_W +: PRIO_W];
        win  = SID_W'(i);
      end
    end
  end
endmodule

// File: rtl/dma_stream_ctx.sv
module dma_stream_ctx
  import dma_arb_pkg::*;
#(
  parameter int N_CHAN = 8,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_hit,
  input  logic              cfg_en,
  input  logic [CH_W-1:0]   cfg_chan,
  input  prio_t             cfg_prio,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_circ,
  input  logic              cfg_m2m,
  input  logic              clr_hit,
  input  logic [FLAG_W-1:0] clr_mask,
  input  logic              done_hit,
  input  logic [ERR_W-1:0]  done_err,
  output logic              active,
  output logic [CH_W-1:0]   chan,
  output prio_t             prio,
  output logic              m2m,
  output logic [FLAG_W-1:0] flags
);
  logic [CNT_W-1:0]  prog;
  logic [CNT_W-1:0]  rem;
  logic              circ;
  logic [CNT_W-1:0]  rem_dec;
  logic              good_beat;
  logic [FLAG_W-1:0] set_vec;
  logic [FLAG_W-1:0] clr_vec;

  assign rem_dec   = rem - 1'b1;
  assign good_beat = done_hit && (done_err == '0);

  always_comb begin
    set_vec = '0;
    set_vec[FL_HALF] = good_beat && (rem_dec == (prog >> 1));
    set_vec[FL_DONE] = good_beat && (rem_dec == '0);
    if (done_hit) set_vec[FL_XERR +: ERR_W] = done_err;
    clr_vec = clr_hit ? clr_mask : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      chan   <= '0;
      prio   <= '0;
      m2m    <= 1'b0;
      circ   <= 1'b0;
      prog   <= '0;
      rem    <= '0;
      flags  <= '0;
    end else begin
      if (cfg_hit) begin
        active <= cfg_en && (cfg_count != '0);
        chan   <= cfg_chan;
        prio   <= cfg_prio;
        m2m    <= cfg_m2m;
        circ   <= cfg_circ;
        prog   <= cfg_count;
        rem    <= cfg_count;
      end else if (done_hit) begin
        if (done_err != '0) begin
          active <= 1'b0;
        end else if (rem_dec == '0) begin
          if (circ) begin
            rem <= prog;
          end else begin
            rem    <= '0;
            active <= 1'b0;
          end
        end else begin
          rem <= rem_dec;
        end
      end
      flags <= (flags & ~clr_vec) | set_vec;
    end
  end

  a_r6_active_has_items: assert property (@(posedge clk) disable iff (rst)
    active |-> (rem != '0));

  a_r10_error_stops: assert property (@(posedge clk) disable iff (rst)
    (done_hit && (done_err != '0) && !cfg_hit) |=> !active);

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_hit |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/dma_stream_arb.sv
module dma_stream_arb
  import dma_arb_pkg::*;
#(
  parameter int N_STREAMS = 8,
  parameter int N_CHAN    = 8,
  parameter int CNT_W     = 16,
  localparam int SID_W = (N_STREAMS > 1) ? $clog2(N_STREAMS) : 1,
  localparam int CH_W  = (N_CHAN > 1) ? $clog2(N_CHAN) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_we,
  input  logic [SID_W-1:0]            cfg_sel,
  input  logic                        cfg_en,
  input  logic [CH_W-1:0]             cfg_chan,
  input  logic [1:0]                  cfg_prio,
  input  logic [CNT_W-1:0]            cfg_count,
  input  logic                        cfg_circ,
  input  logic                        cfg_m2m,
  input  logic                        clr_we,
  input  logic [SID_W-1:0]            clr_sel,
  input  logic [4:0]                  clr_mask,
  input  logic [N_CHAN-1:0]           chan_req,
  input  logic                        beat_done,
  input  logic [2:0]                  beat_err,
  output logic                        grant_valid,
  output logic [SID_W-1:0]            grant_sel,
  output logic [N_STREAMS-1:0]        stream_active,
  output logic [N_STREAMS*FLAG_W-1:0] evt_flags,
  output logic [N_STREAMS-1:0]        irq
);
  logic [N_STREAMS-1:0]        req_vec;
  logic [N_STREAMS*PRIO_W-1:0] prio_flat;
  logic                        any_req;
  logic [SID_W-1:0]            winner;

  for (genvar s = 0; s < N_STREAMS; s++) begin : g_stream
    logic [CH_W-1:0]   chan_s;
    prio_t             prio_s;
    logic              m2m_s;
    logic [FLAG_W-1:0] flags_s;
    logic              cfg_hit_s;
    logic              clr_hit_s;
    logic              done_hit_s;

    assign cfg_hit_s  = cfg_we && (cfg_sel == SID_W'(s));
    assign clr_hit_s  = clr_we && (clr_sel == SID_W'(s));
    assign done_hit_s = grant_valid && beat_done && (grant_sel == SID_W'(s));

    dma_stream_ctx #(.N_CHAN(N_CHAN), .CNT_W(CNT_W)) i_ctx (
      .clk       (clk),
      .rst       (rst),
      .cfg_hit   (cfg_hit_s),
      .cfg_en    (cfg_en),
      .cfg_chan  (cfg_chan),
      .cfg_prio  (prio_t'(cfg_prio)),
      .cfg_count (cfg_count),
      .cfg_circ  (cfg_circ),
      .cfg_m2m   (cfg_m2m),
      .clr_hit   (clr_hit_s),
      .clr_mask  (clr_mask),
      .done_hit  (done_hit_s),
      .done_err  (beat_err),
      .active    (stream_active[s]),
      .chan      (chan_s),
      .prio      (prio_s),
      .m2m       (m2m_s),
      .flags     (flags_s)
    );

    dma_req_mux #(.N_CHAN(N_CHAN)) i_mux (
      .chan_req (chan_req),
      .chan     (chan_s),
      .active   (stream_active[s]),
      .m2m      (m2m_s),
      .req      (req_vec[s])
    );

    assign prio_flat[s*PRIO_W +: PRIO_W] = prio_s;
    assign evt_flags[s*FLAG_W +: FLAG_W] = flags_s;
    assign irq[s] = |flags_s;
  end

  dma_prio_pick #(.N_STREAMS(N_STREAMS)) i_pick (
    .req       (req_vec),
    .prio_flat (prio_flat),
    .any       (any_req),
    .win       (winner)
  );

  // Arbitration only while no beat is outstanding (R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_sel   <= '0;
    end else if (grant_valid) begin
      if (beat_done) grant_valid <= 1'b0;
    end else if (any_req) begin
      grant_valid <= 1'b1;
      grant_sel   <= winner;
    end
  end

  a_r5_hold_grant: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && !beat_done) |=> (grant_valid && $stable(grant_sel)));

  a_r5_idle_after_beat: assert property (@(posedge clk) disable iff (rst)
    (grant_valid && beat_done) |=> !grant_valid);

  a_r2_grant_was_requested: assert property (@(posedge clk) disable iff (rst)
    $rose(grant_valid) |-> |($past(req_vec) & (N_STREAMS'(1) << grant_sel)));
endmodule

// File: tb/test_dma_stream_arb.sv
module test_dma_stream_arb;
  localparam int NS = 8;
  localparam int NC = 8;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst;
  logic cfg_we;
  logic [2:0] cfg_sel;
  logic cfg_en;
  logic [2:0] cfg_chan;
  logic [1:0] cfg_prio;
  logic [CW-1:0] cfg_count;
  logic cfg_circ;
  logic cfg_m2m;
  logic clr_we;
  logic [2:0] clr_sel;
  logic [4:0] clr_mask;
  logic [NC-1:0] chan_req;
  logic beat_done;
  logic [2:0] beat_err;
  logic grant_valid;
  logic [2:0] grant_sel;
  logic [NS-1:0] stream_active;
  logic [NS*5-1:0] evt_flags;
  logic [NS-1:0] irq;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dma_stream_arb #(.N_STREAMS(NS), .N_CHAN(NC), .CNT_W(CW)) i_dma_stream_arb (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_en(cfg_en),
    .cfg_chan(cfg_chan), .cfg_prio(cfg_prio), .cfg_count(cfg_count),
    .cfg_circ(cfg_circ), .cfg_m2m(cfg_m2m), .clr_we(clr_we), .clr_sel(clr_sel),
    .clr_mask(clr_mask), .chan_req(chan_req), .beat_done(beat_done),
    .beat_err(beat_err), .grant_valid(grant_valid), .grant_sel(grant_sel),
    .stream_active(stream_active), .evt_flags(evt_flags), .irq(irq)
  );

  // Priority codes packed two bits per stream, request masks, expected winner
  localparam logic [15:0] V_PRIO [6] = '{16'h0000, 16'h3000, 16'h0884, 16'h0884, 16'hFFFF, 16'hC002};
  localparam logic [7:0]  V_MASK [6] = '{8'hFF, 8'hFF, 8'hFF, 8'hD6, 8'h90, 8'h81};
  localparam int          V_EXP  [6] = '{0, 6, 3, 1, 4, 7};

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; chan_req = '0; beat_done = 1'b0; beat_err = '0;
    cfg_we = 1'b0; clr_we = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg(input int s, input bit en, input int ch, input int pr,
                     input int cnt, input bit circ, input bit m2m);
    cfg_we = 1'b1; cfg_sel = 3'(s); cfg_en = en; cfg_chan = 3'(ch);
    cfg_prio = 2'(pr); cfg_count = CW'(cnt); cfg_circ = circ; cfg_m2m = m2m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clr(input int s, input logic [4:0] m);
    clr_we = 1'b1; clr_sel = 3'(s); clr_mask = m;
    @(negedge clk);
    clr_we = 1'b0;
  endtask

  task automatic do_beat(input logic [2:0] err);
    beat_done = 1'b1; beat_err = err;
    @(negedge clk);
    beat_done = 1'b0; beat_err = '0;
    @(negedge clk);
  endtask

  function automatic int flag(input int s, input int f);
    return int'(evt_flags[s*5+f]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    cfg_sel = '0; cfg_en = 0; cfg_chan = '0; cfg_prio = '0; cfg_count = '0;
    cfg_circ = 0; cfg_m2m = 0; clr_sel = '0; clr_mask = '0;
    do_reset();
    // R1 reset state
    chk("R1 grant", int'(grant_valid), 0);
    chk("R1 active", int'(stream_active), 0);
    chk("R1 flags", int'(evt_flags != '0), 0);
    chk("R1 irq", int'(irq), 0);

    // R3 R4 priority table
    for (int v = 0; v < 6; v++) begin
      do_reset();
      for (int s = 0; s < NS; s++) cfg(s, 1, s, int'(V_PRIO[v][2*s +: 2]), 100, 0, 0);
      chan_req = V_MASK[v];
      @(negedge clk);
      chk("R3 R4 grant valid", int'(grant_valid), 1);
      chk("R3 R4 winner", int'(grant_sel), V_EXP[v]);
    end

    // R5 hold without done, idle after done
    repeat (3) @(negedge clk);
    chk("R5 held", int'(grant_sel), 7);
    beat_done = 1'b1;
    @(negedge clk);
    beat_done = 1'b0;
    chk("R5 idle slot", int'(grant_valid), 0);
    @(negedge clk);
    chk("R5 regrant", int'(grant_valid), 1);

    // R1 reset in the middle of activity
    do_reset();
    chk("R1 mid reset grant", int'(grant_valid), 0);
    chk("R1 mid reset active", int'(stream_active), 0);

    // R7 R8 count of 4, no circular mode
    cfg(2, 1, 2, 0, 4, 0, 0);
    chan_req = 8'h04;
    @(negedge clk);
    chk("R8 grant s2", int'(grant_valid && grant_sel == 2), 1);
    do_beat(3'b000);
    chk("R7 no half yet", flag(2, 0), 0);
    do_beat(3'b000);
    chk("R7 half set", flag(2, 0), 1);
    chk("R8 not done", flag(2, 1), 0);
    do_beat(3'b000);
    do_beat(3'b000);
    chk("R8 done set", flag(2, 1), 1);
    chk("R8 inactive", int'(stream_active[2]), 0);
    chk("R12 irq", int'(irq[2]), 1);
    repeat (3) @(negedge clk);
    chk("R8 no grant", int'(grant_valid), 0);

    // R11 partial clear, then full clear
    clr(2, 5'b00001);
    chk("R11 half cleared", flag(2, 0), 0);
    chk("R11 done kept", flag(2, 1), 1);
    clr(2, 5'b00010);
    chk("R12 irq low", int'(irq[2]), 0);

    // R9 circular with count 2
    do_reset();
    cfg(1, 1, 1, 0, 2, 1, 0);
    chan_req = 8'h02;
    @(negedge clk);
    do_beat(3'b000);
    chk("R7 half at 1", flag(1, 0), 1);
    do_beat(3'b000);
    chk("R9 done", flag(1, 1), 1);
    chk("R9 still active", int'(stream_active[1]), 1);
    chk("R9 regranted", int'(grant_valid && grant_sel == 1), 1);

    // R13 R10 software trigger stream, errors
    do_reset();
    cfg(4, 1, 0, 1, 1, 0, 1);
    @(negedge clk);
    chk("R13 m2m grant", int'(grant_valid && grant_sel == 4), 1);
    do_beat(3'b001);
    chk("R10 xfer err", flag(4, 2), 1);
    chk("R10 not counted", flag(4, 1), 0);
    chk("R10 inactive", int'(stream_active[4]), 0);
    cfg(4, 1, 0, 1, 5, 0, 1);
    @(negedge clk);
    do_beat(3'b110);
    chk("R10 fifo err", flag(4, 3), 1);
    chk("R10 dir err", flag(4, 4), 1);
    chk("R11 sticky", flag(4, 2), 1);
    clr(4, 5'b00100);
    chk("R11 cleared bit2", flag(4, 2), 0);
    chk("R12 irq held", int'(irq[4]), 1);
    clr(4, 5'b11000);
    chk("R12 irq cleared", int'(irq[4]), 0);

    // R2 channel selection and disabled stream
    do_reset();
    cfg(5, 1, 3, 0, 5, 0, 0);
    chan_req = 8'h20;
    repeat (3) @(negedge clk);
    chk("R2 wrong line", int'(grant_valid), 0);
    chan_req = 8'h08;
    @(negedge clk);
    chk("R2 own line", int'(grant_valid && grant_sel == 5), 1);
    do_reset();
    cfg(3, 0, 0, 3, 5, 0, 1);
    repeat (3) @(negedge clk);
    chk("R2 disabled", int'(grant_valid), 0);

    // R6 zero count
    cfg(0, 1, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk("R6 zero count inactive", int'(stream_active[0]), 0);
    chk("R6 zero count no grant", int'(grant_valid), 0);
    cfg(0, 1, 0, 0, 65535, 0, 1);
    @(negedge clk);
    do_beat(3'b000);
    chk("R6 max count active", int'(stream_active[0]), 1);
    chk("R6 max count no half", flag(0, 0), 0);

    summary();
  end
endmodule